// File: doc/BRIEF.md
# Restart-Vector Interrupt Acknowledge Controller

This block is the processor-side handler for a single maskable interrupt request in a small 8-bit core. An interrupt-enable flag is set by an enable command from the instruction decoder and cleared by a disable command. It is also cleared when a request is taken. The request line is looked at only in the cycle the sequencer marks as the sample point of the current instruction, which is one clock before that instruction's final state. A request that is gone by then is lost.

When a request is taken, the controller drives an acknowledge strobe for one cycle and registers the byte that external logic places on the data bus. That byte must be a restart opcode of the form 11nnn111. The controller then saves the address of the next instruction by sending it on a byte stream, high byte first. After that it issues a call vector of n times 8. A byte that does not fit the pattern raises an error pulse, and no push or call follows.

The push stream uses valid/ready. While `push_valid` is high and `push_ready` is low, the byte holds steady. A byte is transferred on each clock edge where both are high. The receiver may stall for any number of cycles.

Top module: `restart_irq_unit`

## Requirements
- R1: After reset the enable flag is clear, and `irq_ack`, `push_valid`, `vec_valid` and `opc_err` are all low.
- R2: While the enable flag is clear, a request at a sample point produces no acknowledge.
- R3: A request is taken only when `irq_req` and `irq_sample` are both high at a clock edge, the enable flag is set and the unit is idle. `irq_ack` is then high for exactly the one following cycle.
- R4: Taking a request clears the enable flag, and later requests are ignored until `ei_cmd` is given again. If `ei_cmd` arrives in the same cycle as a taken request, the flag ends up clear. If `ei_cmd` and `di_cmd` arrive together, the flag ends up clear. `di_cmd` alone also clears it.
- R5: `bus_data` is registered at the clock edge that ends the acknowledge cycle. A byte with bits 7:6 = 11 and bits 2:0 = 111 is accepted as restart number n = bits 5:3.
- R6: If the captured byte does not fit that pattern, `opc_err` is high for the one cycle after acknowledge. No byte is pushed, no vector is issued, and the enable flag stays clear.
- R7: The return address is the value of `pc_next` at the edge where the request is taken. It is pushed as two bytes, bits 15:8 first and then bits 7:0. `push_data` stays stable while the receiver stalls.
- R8: In the cycle after the last push byte is transferred, `vec_valid` is high for one cycle, with `vec_addr` = n × 8 (restart 0 gives 0000h and restart 7 gives 0038h). `vec_valid` is never high before both bytes have been transferred.
- R9: While a service sequence is in progress, requests are not taken, even if `ei_cmd` has set the flag again. The re-set flag remains in effect for the first request after the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ei_cmd | input | 1 | Enable-interrupt command pulse |
| di_cmd | input | 1 | Disable-interrupt command pulse |
| irq_req | input | 1 | Maskable interrupt request |
| irq_sample | input | 1 | Marks the request sample point of the current instruction |
| pc_next | input | 16 | Address of the next instruction |
| bus_data | input | 8 | Data bus byte read during acknowledge |
| irq_ack | output | 1 | Acknowledge strobe, one cycle |
| push_valid | output | 1 | Return-address byte valid |
| push_ready | input | 1 | Stack side can take a byte |
| push_data | output | 8 | Return-address byte, high first |
| vec_valid | output | 1 | Call vector valid, one cycle |
| vec_addr | output | 16 | Call target, restart number times 8 |
| opc_err | output | 1 | Captured byte is not a restart opcode |

## Verification
The hardest case to reach is a request that arrives while a service sequence is still running and the enable flag has already been set again. Any acknowledge in that window would break the sequence. To create it, the bench issues `ei_cmd` in the decode cycle and then holds the request and sample point high throughout a return-address push. Random stalls on `push_ready` stretch that push. The bench then starts a new service without a fresh enable command, which shows that the flag set in mid-sequence was kept.

// File: rtl/rsti_pkg.sv
package rsti_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACK    = 3'd1,
    ST_DECODE = 3'd2,
    ST_PUSH   = 3'd3,
    ST_JUMP   = 3'd4
  } ctl_state_t;

  localparam int OPC_W = 8;
  localparam int SLOT_SHIFT = 3;
endpackage

// File: rtl/rsti_enable_ff.sv
module rsti_enable_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic take_i,
  output logic en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)              en_o <= 1'b0;
    else if (take_i || clr_i) en_o <= 1'b0;
    else if (set_i)          en_o <= 1'b1;
  end

  // R4
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !en_o);

  // R4
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i) |=> !en_o);
endmodule

// File: rtl/rsti_opcode_dec.sv
module rsti_opcode_dec #(
  parameter int AW = 16
) (
  input  logic [rsti_pkg::OPC_W-1:0] opcode_i,
  output logic                       ok_o,
  output logic [AW-1:0]              target_o
);
  import rsti_pkg::*;
  localparam int NUM_W = 3;
  localparam int PAD_W = AW - NUM_W - SLOT_SHIFT;

  logic [NUM_W-1:0] slot;

  always_comb begin
    slot     = opcode_i[5:3];
    ok_o     = (opcode_i[7:6] == 2'b11) && (opcode_i[2:0] == 3'b111);
    target_o = {{PAD_W{1'b0}}, slot, {SLOT_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/rsti_push_ser.sv
module rsti_push_ser #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] word_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [BW-1:0] data_o,
  output logic          done_o
);
  localparam int NB = AW / BW;
  localparam int CW = $clog2(NB + 1);

  logic [AW-1:0] shreg;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load_i) begin
      shreg <= word_i;
      left  <= CW'(NB);
    end else if (valid_o && ready_i) begin
      shreg <= shreg << BW;
      left  <= left - 1'b1;
    end
  end

  always_comb begin
    valid_o = (left != '0);
    data_o  = shreg[AW-1 -: BW];
    done_o  = valid_o && ready_i && (left == CW'(1));
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/restart_irq_unit.sv
module restart_irq_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ei_cmd,
  input  logic          di_cmd,
  input  logic          irq_req,
  input  logic          irq_sample,
  input  logic [AW-1:0] pc_next,
  input  logic [7:0]    bus_data,
  output logic          irq_ack,
  output logic          push_valid,
  input  logic          push_ready,
  output logic [7:0]    push_data,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  output logic          opc_err
);
  import rsti_pkg::*;

  ctl_state_t        state, state_nx;
  logic              ie;
  logic              take;
  logic [OPC_W-1:0]  opc_q;
  logic [AW-1:0]     pc_q;
  logic              opc_ok;
  logic              push_done;
  logic              push_load;

  assign take      = (state == ST_IDLE) && irq_sample && irq_req && ie;
  assign push_load = (state == ST_DECODE) && opc_ok;

  rsti_enable_ff u_ie (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ei_cmd),
    .clr_i  (di_cmd),
    .take_i (take),
    .en_o   (ie)
  );

  rsti_opcode_dec #(.AW(AW)) u_dec (
    .opcode_i (opc_q),
    .ok_o     (opc_ok),
    .target_o (vec_addr)
  );

  rsti_push_ser #(.AW(AW), .BW(8)) u_push (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (push_load),
    .word_i  (pc_q),
    .ready_i (push_ready),
    .valid_o (push_valid),
    .data_o  (push_data),
    .done_o  (push_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (take) state_nx = ST_ACK;
      ST_ACK:    state_nx = ST_DECODE;
      ST_DECODE: state_nx = opc_ok ? ST_PUSH : ST_IDLE;
      ST_PUSH:   if (push_done) state_nx = ST_JUMP;
      ST_JUMP:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      opc_q <= '0;
      pc_q  <= '0;
    end else begin
      state <= state_nx;
      if (take)            pc_q  <= pc_next;
      if (state == ST_ACK) opc_q <= bus_data;
    end
  end

  assign irq_ack   = (state == ST_ACK);
  assign opc_err   = (state == ST_DECODE) && !opc_ok;
  assign vec_valid = (state == ST_JUMP);

  // R3
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R2
  masked_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && state == ST_IDLE) |=> !irq_ack);

  // R6
  err_no_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opc_err |=> (!push_valid && !vec_valid && !ie));

  // R8
  vec_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(push_valid && push_ready));

  // R9
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH) |=> !irq_ack);
endmodule

// File: tb/sim_restart_irq_unit.sv
`timescale 1ns/1ps
module sim_restart_irq_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ei = 0, di = 0, irq = 0, smp = 0, rdy = 0;
  logic [15:0] pc = 0;
  logic [7:0] bus = 0;
  logic ack, pv, vv, err;
  logic [7:0] pd;
  logic [15:0] va;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  restart_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .ei_cmd(ei), .di_cmd(di), .irq_req(irq),
    .irq_sample(smp), .pc_next(pc), .bus_data(bus), .irq_ack(ack),
    .push_valid(pv), .push_ready(rdy), .push_data(pd), .vec_valid(vv),
    .vec_addr(va), .opc_err(err)
  );

  function automatic logic [7:0] mk_op(input logic [2:0] n);
    return {2'b11, n, 3'b111};
  endfunction
  function automatic bit op_ok(input logic [7:0] b);
    return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
  endfunction
  function automatic logic [15:0] exp_vec(input logic [7:0] b);
    return 16'(b[5:3]) * 16'd8;
  endfunction

  task automatic check(input bit good, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input bit e, input bit d);
    @(negedge clk); ei = e; di = d;
    @(negedge clk); ei = 0; di = 0;
  endtask

  task automatic try_req(input bit exp, input string req);
    @(negedge clk); irq = 1; smp = 1; pc = 16'($urandom);
    @(negedge clk); irq = 0; smp = 0;
    check(ack == exp, req, "ack after request", 32'(ack), 32'(exp));
  endtask

  task automatic service(input logic [15:0] pcv, input logic [7:0] op,
                         input bit poke, input bit ei_same);
    int got, cyc;
    logic [7:0] want;
    @(negedge clk); irq = 1; smp = 1; pc = pcv; ei = ei_same;
    @(negedge clk); irq = 0; smp = 0; ei = 0; pc = 16'($urandom);
    check(ack == 1'b1, "R3", "ack after taken request", 32'(ack), 1);
    bus = op;
    @(negedge clk); bus = 8'($urandom);
    check(ack == 1'b0, "R3", "ack width", 32'(ack), 0);
    if (!op_ok(op)) begin
      check(err == 1'b1, "R6", "opc_err on bad byte", 32'(err), 1);
      check(pv == 1'b0, "R6", "no push on bad byte", 32'(pv), 0);
      @(negedge clk);
      check(err == 1'b0 && vv == 1'b0 && pv == 1'b0, "R6", "quiet after error",
            32'({err, vv, pv}), 0);
      return;
    end
    check(err == 1'b0, "R5", "valid byte accepted", 32'(err), 0);
    got = 0; cyc = 0;
    if (poke) ei = 1;
    while (got < 2 && cyc < 200) begin
      if (poke && cyc == 1) begin ei = 0; irq = 1; smp = 1; end
      if (poke && cyc > 0) check(ack == 1'b0, "R9", "no ack while busy", 32'(ack), 0);
      if (vv) check(1'b0, "R8", "vector before push done", 32'(vv), 0);
      rdy = ($urandom % 3) != 0;
      if (pv) begin
        want = (got == 0) ? pcv[15:8] : pcv[7:0];
        check(pd == want, "R7", "push byte", 32'(pd), 32'(want));
        if (rdy) got++;
      end
      @(negedge clk);
      cyc++;
    end
    rdy = 0; irq = 0; smp = 0;
    check(got == 2, "R7", "two bytes pushed", 32'(got), 2);
    check(vv == 1'b1, "R8", "vector strobe", 32'(vv), 1);
    check(va == exp_vec(op), "R8", "vector address", 32'(va), 32'(exp_vec(op)));
    if (poke) check(ack == 1'b0, "R9", "no ack in jump", 32'(ack), 0);
    @(negedge clk);
    check(vv == 1'b0, "R8", "vector one cycle", 32'(vv), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] op;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(ack == 0 && pv == 0 && vv == 0 && err == 0, "R1", "outputs in reset",
          32'({ack, pv, vv, err}), 0);
    rst_n = 1;
    @(negedge clk);
    check(ack == 0 && pv == 0 && vv == 0 && err == 0, "R1", "outputs after reset",
          32'({ack, pv, vv, err}), 0);
    try_req(0, "R1");
    try_req(0, "R2");

    pulse(1, 0);
    @(negedge clk); irq = 1; smp = 0;
    repeat (3) begin
      @(negedge clk);
      check(ack == 0, "R3", "no sample point", 32'(ack), 0);
    end
    irq = 0; smp = 1;
    @(negedge clk); smp = 0;
    @(negedge clk);
    check(ack == 0, "R3", "sample without request", 32'(ack), 0);

    service(16'h1234, 8'hEF, 0, 0);
    try_req(0, "R4");

    pulse(1, 0);
    service(16'h00FF, mk_op(3'd0), 0, 1);
    try_req(0, "R4");

    pulse(1, 1);
    try_req(0, "R4");
    pulse(1, 0);
    pulse(0, 1);
    try_req(0, "R4");

    pulse(1, 0);
    service(16'h5A5A, 8'hC3, 0, 0);
    try_req(0, "R6");

    pulse(1, 0);
    service(16'hBEEF, mk_op(3'd7), 1, 0);
    service(16'hABCD, mk_op(3'd2), 0, 0);

    for (int i = 0; i < 40; i++) begin
      pulse(1, 0);
      op = mk_op(3'($urandom));
      if (($urandom % 5) == 0) op = op ^ (8'h01 << ($urandom % 3));
      service(16'($urandom), op, ($urandom % 4) == 0, 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule